// File: doc/BRIEF.md
# Endpoint Control Register Bank

This block keeps the control and status word of each endpoint of a full-speed USB device. There are eight endpoints by default. Each 16-bit word mixes three kinds of field. Configuration fields take whatever software writes. The handshake-state and data-toggle fields invert on every bit written as 1. The two transfer-complete flags can only be cleared by software, by writing 0 to them.

The protocol engine works on the same words through per-endpoint event lines. A completion pulse sets a flag, and a flip pulse inverts a data toggle after a successful transaction. When software and hardware act on the same word in one cycle, the result is fixed by rule. A hardware set beats a software clear. A software toggle and a hardware flip combine as an XOR.

Every field is also driven out as a flat per-endpoint vector, so the engine reads the handshake state, type, kind, address and toggles without using the bus port. Writes take effect at the clock edge. Read data is a combinational view of the register selected by the index.

Top module: `ep_ctl_regfile`

## Requirements
- R1: Reset clears every register to 0x0000, so both handshake states read 00 (disabled) and all outputs are 0.
- R2: A bus write changes only the register selected by `bus_idx`, and a hardware event on endpoint n changes only register n.
- R3: Bit 15 (receive complete) and bit 7 (transmit complete) are cleared by a bus write of 0 and kept by a write of 1. A bus write never sets them.
- R4: The receive handshake field (bits 13:12) and the transmit handshake field (bits 5:4) invert each bit written as 1 and keep each bit written as 0. Reads return the exact 2-bit value.
- R5: The receive toggle (bit 14) and the transmit toggle (bit 6) invert when written with 1 and hold when written with 0.
- R6: The type field (bits 10:9; control=0, isochronous=1, bulk=2, interrupt=3), the kind bit (bit 8) and the address field (bits 3:0) take the written value directly.
- R7: A pulse on `hw_rx_done`/`hw_tx_done` sets the matching flag. It wins over a software clear in the same cycle.
- R8: A pulse on `hw_rx_flip`/`hw_tx_flip` inverts the matching toggle. A software toggle-write in the same cycle combines with it as an XOR.
- R9: Bit 11 always reads 0, and writes to it are ignored.
- R10: The per-endpoint outputs carry each register's fields, with endpoint n in slice n of each vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_idx | input | 3 | Endpoint index for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Selected register, combinational |
| hw_rx_done | input | 8 | Per-endpoint receive-complete set pulse |
| hw_tx_done | input | 8 | Per-endpoint transmit-complete set pulse |
| hw_rx_flip | input | 8 | Per-endpoint receive toggle flip pulse |
| hw_tx_flip | input | 8 | Per-endpoint transmit toggle flip pulse |
| rx_done_o | output | 8 | Receive-complete flags |
| tx_done_o | output | 8 | Transmit-complete flags |
| rx_tog_o | output | 8 | Receive data toggles |
| tx_tog_o | output | 8 | Transmit data toggles |
| rx_hs_o | output | 16 | Receive handshake states, 2 bits each |
| tx_hs_o | output | 16 | Transmit handshake states, 2 bits each |
| ep_type_o | output | 16 | Endpoint types, 2 bits each |
| ep_kind_o | output | 8 | Endpoint kind bits |
| ep_addr_o | output | 32 | Endpoint addresses, 4 bits each |

## Verification
A bus write or hardware pulse is registered at one rising edge, and its effect is due one cycle later on both `bus_rdata` and the field outputs, because both paths are combinational after the register. Each stimulus in the bench is driven on a falling edge and held across exactly one rising edge. The result is then sampled on the next falling edge, with strobes already low, so every check lands in the first cycle the new value is valid. Same-cycle conflicts are built by putting the software write and the hardware pulse on the same falling edge.

// File: rtl/ep_ctl_pkg.sv
package ep_ctl_pkg;

  localparam int unsigned REG_W = 16;

  // Field order is fixed: the protocol engine and software decode these positions.
  typedef struct packed {
    logic       rx_done;   // 15
    logic       rx_tog;    // 14
    logic [1:0] rx_hs;     // 13:12
    logic       rsvd;      // 11
    logic [1:0] ep_type;   // 10:9
    logic       kind;      // 8
    logic       tx_done;   // 7
    logic       tx_tog;    // 6
    logic [1:0] tx_hs;     // 5:4
    logic [3:0] addr;      // 3:0
  } ep_word_t;

  typedef enum logic [1:0] {
    EPT_CONTROL = 2'd0,
    EPT_ISO     = 2'd1,
    EPT_BULK    = 2'd2,
    EPT_INTR    = 2'd3
  } ep_kind_e;

endpackage

// File: rtl/ep_ctl_wdec.sv
module ep_ctl_wdec #(
  parameter int unsigned NUM_EP = 8,
  localparam int unsigned IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  output logic [NUM_EP-1:0] sel
);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_sel
    assign sel[i] = wr && (idx == IDX_W'(i));
  end

endmodule

// File: rtl/ep_ctl_slot.sv
module ep_ctl_slot
  import ep_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  ep_word_t wdata,
  input  logic     hw_rx_set,
  input  logic     hw_tx_set,
  input  logic     hw_rx_flip,
  input  logic     hw_tx_flip,
  output ep_word_t q
);

  ep_word_t cur_q;
  ep_word_t nxt;
  logic     ld;

  assign ld = wr_en | hw_rx_set | hw_tx_set | hw_rx_flip | hw_tx_flip;

  always_comb begin
    nxt = cur_q;
    if (wr_en) begin
      nxt.rx_done = cur_q.rx_done & wdata.rx_done;
      nxt.tx_done = cur_q.tx_done & wdata.tx_done;
      nxt.rx_tog  = cur_q.rx_tog ^ wdata.rx_tog;
      nxt.tx_tog  = cur_q.tx_tog ^ wdata.tx_tog;
      nxt.rx_hs   = cur_q.rx_hs ^ wdata.rx_hs;
      nxt.tx_hs   = cur_q.tx_hs ^ wdata.tx_hs;
      nxt.ep_type = wdata.ep_type;
      nxt.kind    = wdata.kind;
      nxt.addr    = wdata.addr;
    end
    if (hw_rx_flip) nxt.rx_tog = ~nxt.rx_tog;
    if (hw_tx_flip) nxt.tx_tog = ~nxt.tx_tog;
    if (hw_rx_set)  nxt.rx_done = 1'b1;
    if (hw_tx_set)  nxt.tx_done = 1'b1;
    nxt.rsvd = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (ld) begin
      cur_q <= nxt;
    end
  end

  assign q = cur_q;

  // Software alone can never raise a completion flag.
  assert_done_only_hw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cur_q.rx_done) |-> $past(hw_rx_set));

  // A hardware set is never lost to a concurrent clear.
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_tx_set |=> cur_q.tx_done);

  // Handshake state moves only on a bus write.
  assert_hs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(cur_q.rx_hs) && $stable(cur_q.tx_hs)));

  // A lone hardware flip always inverts the toggle.
  assert_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && hw_rx_flip) |=> (cur_q.rx_tog != $past(cur_q.rx_tog)));

  // Configuration fields hold without a write.
  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(cur_q.ep_type) && $stable(cur_q.kind) && $stable(cur_q.addr)));

endmodule

// File: rtl/ep_ctl_rdmux.sv
module ep_ctl_rdmux #(
  parameter int unsigned NUM_EP = 8,
  parameter int unsigned REG_W  = 16,
  localparam int unsigned IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic [NUM_EP-1:0][REG_W-1:0] regs,
  input  logic [IDX_W-1:0]             idx,
  output logic [REG_W-1:0]             rdata
);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (idx == IDX_W'(i)) rdata = regs[i];
    end
  end

endmodule

// File: rtl/ep_ctl_regfile.sv
module ep_ctl_regfile
  import ep_ctl_pkg::*;
#(
  parameter int unsigned NUM_EP = 8,
  localparam int unsigned IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [IDX_W-1:0]      bus_idx,
  input  logic [REG_W-1:0]      bus_wdata,
  output logic [REG_W-1:0]      bus_rdata,
  input  logic [NUM_EP-1:0]     hw_rx_done,
  input  logic [NUM_EP-1:0]     hw_tx_done,
  input  logic [NUM_EP-1:0]     hw_rx_flip,
  input  logic [NUM_EP-1:0]     hw_tx_flip,
  output logic [NUM_EP-1:0]     rx_done_o,
  output logic [NUM_EP-1:0]     tx_done_o,
  output logic [NUM_EP-1:0]     rx_tog_o,
  output logic [NUM_EP-1:0]     tx_tog_o,
  output logic [2*NUM_EP-1:0]   rx_hs_o,
  output logic [2*NUM_EP-1:0]   tx_hs_o,
  output logic [2*NUM_EP-1:0]   ep_type_o,
  output logic [NUM_EP-1:0]     ep_kind_o,
  output logic [4*NUM_EP-1:0]   ep_addr_o
);

  logic [NUM_EP-1:0]            wr_sel;
  logic [NUM_EP-1:0][REG_W-1:0] reg_flat;
  ep_word_t                     wword;

  assign wword = ep_word_t'(bus_wdata);

  ep_ctl_wdec #(.NUM_EP(NUM_EP)) u_wdec (
    .wr  (bus_wr),
    .idx (bus_idx),
    .sel (wr_sel)
  );

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    ep_word_t slot_q;

    ep_ctl_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_sel[i]),
      .wdata      (wword),
      .hw_rx_set  (hw_rx_done[i]),
      .hw_tx_set  (hw_tx_done[i]),
      .hw_rx_flip (hw_rx_flip[i]),
      .hw_tx_flip (hw_tx_flip[i]),
      .q          (slot_q)
    );

    assign reg_flat[i]        = slot_q;
    assign rx_done_o[i]       = slot_q.rx_done;
    assign tx_done_o[i]       = slot_q.tx_done;
    assign rx_tog_o[i]        = slot_q.rx_tog;
    assign tx_tog_o[i]        = slot_q.tx_tog;
    assign rx_hs_o[2*i +: 2]  = slot_q.rx_hs;
    assign tx_hs_o[2*i +: 2]  = slot_q.tx_hs;
    assign ep_type_o[2*i +: 2] = slot_q.ep_type;
    assign ep_kind_o[i]       = slot_q.kind;
    assign ep_addr_o[4*i +: 4] = slot_q.addr;
  end

  ep_ctl_rdmux #(.NUM_EP(NUM_EP), .REG_W(REG_W)) u_rdmux (
    .regs  (reg_flat),
    .idx   (bus_idx),
    .rdata (bus_rdata)
  );

  // At most one register is written per cycle.
  assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  // With no strobe, no register is selected for writing.
  assert_idle_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |-> (wr_sel == '0));

endmodule

// File: tb/ep_ctl_regfile_tb.sv
module ep_ctl_regfile_tb;

  localparam int NEP = 8;
  localparam int VW  = 44;
  localparam int NV  = 14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_idx;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [7:0]  hw_rx_done, hw_tx_done, hw_rx_flip, hw_tx_flip;
  logic [7:0]  rx_done_o, tx_done_o, rx_tog_o, tx_tog_o, ep_kind_o;
  logic [15:0] rx_hs_o, tx_hs_o, ep_type_o;
  logic [31:0] ep_addr_o;

  int vec_cnt = 0;
  int err_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ep_ctl_regfile #(.NUM_EP(NEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_idx(bus_idx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_rx_done(hw_rx_done), .hw_tx_done(hw_tx_done),
    .hw_rx_flip(hw_rx_flip), .hw_tx_flip(hw_tx_flip),
    .rx_done_o(rx_done_o), .tx_done_o(tx_done_o),
    .rx_tog_o(rx_tog_o), .tx_tog_o(tx_tog_o),
    .rx_hs_o(rx_hs_o), .tx_hs_o(tx_hs_o), .ep_type_o(ep_type_o),
    .ep_kind_o(ep_kind_o), .ep_addr_o(ep_addr_o)
  );

  // {req, wr, idx, wdata, done-set{rx,tx}, flip{rx,tx}, expected read of idx}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd6, 1'b1, 3'd2, 16'h8585, 2'b00, 2'b00, 16'h0505}, // R6 bulk, kind, addr 5
    {4'd4, 1'b1, 3'd2, 16'hB5A5, 2'b00, 2'b00, 16'h3525}, // R4 rx_hs 11, tx_hs 10
    {4'd4, 1'b1, 3'd2, 16'h9595, 2'b00, 2'b00, 16'h2535}, // R4 rx_hs 10, tx_hs 11
    {4'd7, 1'b0, 3'd2, 16'h0000, 2'b11, 2'b00, 16'hA5B5}, // R7 hw sets both flags
    {4'd3, 1'b1, 3'd2, 16'h8585, 2'b00, 2'b00, 16'hA5B5}, // R3 write 1 keeps flags
    {4'd3, 1'b1, 3'd2, 16'h0585, 2'b00, 2'b00, 16'h25B5}, // R3 write 0 clears rx flag
    {4'd7, 1'b1, 3'd2, 16'h8505, 2'b01, 2'b00, 16'h25B5}, // R7 set beats clear
    {4'd5, 1'b1, 3'd2, 16'hC5C5, 2'b00, 2'b00, 16'h65F5}, // R5 both toggles invert
    {4'd8, 1'b0, 3'd2, 16'h0000, 2'b00, 2'b10, 16'h25F5}, // R8 hw flip rx
    {4'd8, 1'b1, 3'd2, 16'hC5C5, 2'b00, 2'b10, 16'h25B5}, // R8 sw^hw cancel on rx
    {4'd9, 1'b1, 3'd5, 16'h0E0F, 2'b00, 2'b00, 16'h060F}, // R9 bit 11 dropped
    {4'd2, 1'b0, 3'd2, 16'h0000, 2'b00, 2'b00, 16'h25B5}, // R2 ep2 untouched
    {4'd6, 1'b1, 3'd2, 16'h808A, 2'b00, 2'b00, 16'h20BA}, // R6 control, addr A
    {4'd7, 1'b0, 3'd2, 16'h0000, 2'b10, 2'b00, 16'hA0BA}  // R7 hw rx set
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_wr = 1'b0; bus_idx = '0; bus_wdata = '0;
    hw_rx_done = '0; hw_tx_done = '0; hw_rx_flip = '0; hw_tx_flip = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      err_cnt++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every register reads zero after reset
    for (int i = 0; i < NEP; i++) begin
      bus_idx = 3'(i);
      #1 check("R1", 32'(bus_rdata), 32'h0);
    end

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      @(negedge clk);
      idle();
      bus_wr    = e[39];
      bus_idx   = e[38:36];
      bus_wdata = e[35:20];
      hw_rx_done[e[38:36]] = e[19];
      hw_tx_done[e[38:36]] = e[18];
      hw_rx_flip[e[38:36]] = e[17];
      hw_tx_flip[e[38:36]] = e[16];
      @(negedge clk);
      bus_wr = 1'b0;
      hw_rx_done = '0; hw_tx_done = '0; hw_rx_flip = '0; hw_tx_flip = '0;
      #1 check($sformatf("R%0d vec %0d", e[43:40], v), 32'(bus_rdata), 32'(e[15:0]));
    end

    // R10: field outputs mirror the registers
    check("R10 rx_hs ep2",  32'(rx_hs_o[5:4]),     32'h2);
    check("R10 tx_hs ep2",  32'(tx_hs_o[5:4]),     32'h3);
    check("R10 type ep5",   32'(ep_type_o[11:10]), 32'h3);
    check("R10 addr ep5",   32'(ep_addr_o[23:20]), 32'hF);
    check("R10 addr ep2",   32'(ep_addr_o[11:8]),  32'hA);

    // R2: hardware event on ep7 touches only ep7
    @(negedge clk);
    hw_rx_done[7] = 1'b1;
    @(negedge clk);
    hw_rx_done = '0;
    #1 check("R2 rx_done_o", 32'(rx_done_o), 32'h84);
    check("R2 tx_done_o", 32'(tx_done_o), 32'h04);

    // R3: a write of all ones cannot set a clear flag (ep0)
    @(negedge clk);
    bus_wr = 1'b1; bus_idx = 3'd0; bus_wdata = 16'h8080;
    @(negedge clk);
    bus_wr = 1'b0;
    #1 check("R3 no sw set", 32'(bus_rdata), 32'h0);

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 done_o", 32'({rx_done_o, tx_done_o}), 32'h0);
    check("R1 hs_o", {rx_hs_o, tx_hs_o}, 32'h0);
    bus_idx = 3'd5;
    #1 check("R1 ep5", 32'(bus_rdata), 32'h0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule